// File: doc/BRIEF.md
# Framed I/Q Serial Output Port

This block sends received I/Q sample pairs off-chip over a three-wire synchronous serial link: a bit clock, a data line and a frame-sync pulse. A producer offers one I word and one Q word together through a valid/ready handshake. The block shifts the I word out MSB first, then the Q word MSB first, with no gap between them. The clock and frame sync are always outputs.

The bit clock comes from dividing the system clock. Each bit slot lasts `2*cfg_half_div` system clocks. Data changes at the start of a slot, on the inactive clock edge. The active edge falls in the middle of the slot, so the receiver samples stable data. Configuration inputs select the following:
- the clock gating mode (gated to frame activity, free running while enabled, or off);
- an early frame-sync slot;
- clock polarity;
- whether frames start from the port enable alone or also need a receive-enable strobe;
- five optional trailing clocks after each frame.

If the port enable drops part way through a frame, the frame still completes, including any trailing clocks, before the clock stops.

Top module: `iqs_serial_out`

## Requirements
- R1: After reset, with `port_en` low and all configuration inputs at 0, `ser_clk`, `ser_data`, `ser_fs` and `smp_ready` are all 0, and no sample pair is accepted while `port_en` is low.
- R2: An accepted pair is sent as 2*WORD_W consecutive bits: the I word MSB first, then the Q word MSB first. Each bit is valid at an active clock edge, which is the rising edge of `ser_clk` when `cfg_clk_inv`=0.
- R3: With `cfg_fs_early`=0, `ser_fs` is high at exactly one active edge per frame, the edge that carries the I-word MSB.
- R4: With `cfg_fs_early`=1, each frame starts with one extra slot in which `ser_fs` is high and `ser_data` is 0. The I-word MSB follows at the next active edge, and `ser_fs` is low there.
- R5: With `cfg_clk_mode`=00, `ser_clk` produces active edges only for slots that belong to a frame (lead slot, data bits, trailing clocks). While no frame is in progress it stays at its idle level.
- R6: With `cfg_clk_mode`=01, `ser_clk` toggles continuously while `port_en` is high, even when no sample is offered.
- R7: With `cfg_clk_mode` bit 1 set (10 or 11), `ser_clk` produces no active edges, `ser_data` and `ser_fs` stay 0, and `smp_ready` stays 0.
- R8: With `cfg_clk_inv`=1, `ser_clk` is inverted: it idles high and its falling edge is the active edge. The frame content is unchanged.
- R9: With `cfg_start_sel`=1, no frame starts while `rx_strobe` is low. Once `rx_strobe` is high, frames start as with `cfg_start_sel`=0.
- R10: With `cfg_trail`=1, exactly 5 active edges with `ser_data`=0 and `ser_fs`=0 follow the last data bit of every frame. With `cfg_trail`=0, none follow.
- R11: Dropping `port_en` after a pair has been accepted does not cut the frame short: all data bits and any trailing clocks are still produced.
- R12: `ser_data` changes only at a slot boundary, which is the inactive clock edge, so it is stable around every active edge.
- R13: Successive active edges of a running clock are exactly 2*`cfg_half_div` system clocks apart.
- R14: With `cfg_fs_early`=0, `cfg_trail`=0 and a pair offered at every frame end, frames follow back to back: the next I-word MSB, with frame sync, comes at the active edge right after the previous Q-word LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port enable |
| rx_strobe | input | 1 | Receive-enable strobe, used as a start qualifier when `cfg_start_sel`=1 |
| cfg_clk_mode | input | 2 | 00 gated, 01 free running, 1x off |
| cfg_fs_early | input | 1 | 1 places frame sync one slot before the I MSB |
| cfg_clk_inv | input | 1 | Inverts `ser_clk` |
| cfg_start_sel | input | 1 | 0 starts frames on `port_en`, 1 also requires `rx_strobe` |
| cfg_trail | input | 1 | Appends 5 trailing clocks per frame |
| cfg_half_div | input | DIV_W | Half bit period in system clocks (0 acts as 1) |
| smp_valid | input | 1 | Sample pair offered |
| smp_i | input | WORD_W | I word |
| smp_q | input | WORD_W | Q word |
| smp_ready | output | 1 | Pair accepted this cycle when `smp_valid` is also high |
| ser_clk | output | 1 | Serial bit clock |
| ser_data | output | 1 | Serial data |
| ser_fs | output | 1 | Frame sync |

## Verification
The bench targets the slot accounting at the frame edges:
- An early frame-sync slot that was missing, or that carried data, would shift every bit by one and misplace the sync.
- A trailing-clock counter that was off by one would emit four or six tail edges.
- A gated clock that leaked into idle slots would show edges with no frame in progress.

It also targets the start and stop conditions. A design that ignored the strobe qualifier would accept samples early. One that stopped on the enable falling would truncate the frame. One that inserted an idle slot between frames would break back-to-back streaming. Each of these shows up as a wrong edge count or a displaced bit.

// File: rtl/iqs_pkg.sv
`timescale 1ns/1ps
package iqs_pkg;
   typedef enum logic [1:0] {
      SL_IDLE = 2'd0,
      SL_LEAD = 2'd1,
      SL_BITS = 2'd2,
      SL_TAIL = 2'd3
   } slot_e;

   localparam int TAIL_CLKS = 5;

   localparam logic [1:0] CK_GATED = 2'b00;
   localparam logic [1:0] CK_FREE  = 2'b01;
endpackage

// File: rtl/iqs_clkdiv.sv
`timescale 1ns/1ps
module iqs_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_div,
   output logic             ph,
   output logic             fall_tk
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim;
   logic             term;

   assign lim     = (half_div == '0) ? '0 : half_div - DIV_W'(1);
   assign term    = run && (cnt_q == lim);
   assign fall_tk = term && ph;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q <= '0;
         ph    <= 1'b0;
      end else if (term) begin
         cnt_q <= '0;
         ph    <= ~ph;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   // R13
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !term) |=> $stable(ph));

   // R13
   stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !ph);
endmodule

// File: rtl/iqs_frame_seq.sv
`timescale 1ns/1ps
module iqs_frame_seq
   import iqs_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fall_tk,
   input  logic              port_en,
   input  logic              start_sel,
   input  logic              rx_strobe,
   input  logic              fs_early,
   input  logic              trail,
   input  logic              smp_valid,
   input  logic [WORD_W-1:0] smp_i,
   input  logic [WORD_W-1:0] smp_q,
   output logic              smp_ready,
   output logic              dat_q,
   output logic              fs_q,
   output logic              act_q,
   output logic              busy
);
   localparam int FR_W  = 2 * WORD_W;
   localparam int IDX_W = $clog2(FR_W);
   localparam int TRL_W = $clog2(TAIL_CLKS + 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FR_W - 1);
   localparam logic [TRL_W-1:0] TRL_LAST = TRL_W'(TAIL_CLKS - 1);

   slot_e            st_q;
   logic [IDX_W-1:0] idx_q;
   logic [TRL_W-1:0] trl_q;
   logic [FR_W-1:0]  sh_q;
   logic             at_end;
   logic             go_ok;
   logic             take;

   assign busy   = (st_q != SL_IDLE);
   assign at_end = (st_q == SL_IDLE)
                || ((st_q == SL_BITS) && (idx_q == IDX_LAST) && !trail)
                || ((st_q == SL_TAIL) && (trl_q == TRL_LAST));
   assign go_ok     = port_en && (!start_sel || rx_strobe);
   assign smp_ready = fall_tk && at_end && go_ok && !clr;
   assign take      = smp_ready && smp_valid;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         st_q  <= SL_IDLE;
         idx_q <= '0;
         trl_q <= '0;
         sh_q  <= '0;
         dat_q <= 1'b0;
         fs_q  <= 1'b0;
         act_q <= 1'b0;
      end else if (fall_tk) begin
         if (take) begin
            fs_q  <= 1'b1;
            act_q <= 1'b1;
            idx_q <= '0;
            trl_q <= '0;
            if (fs_early) begin
               st_q  <= SL_LEAD;
               sh_q  <= {smp_i, smp_q};
               dat_q <= 1'b0;
            end else begin
               st_q  <= SL_BITS;
               sh_q  <= {smp_i[WORD_W-2:0], smp_q, 1'b0};
               dat_q <= smp_i[WORD_W-1];
            end
         end else if (at_end) begin
            st_q  <= SL_IDLE;
            dat_q <= 1'b0;
            fs_q  <= 1'b0;
            act_q <= 1'b0;
         end else begin
            fs_q  <= 1'b0;
            act_q <= 1'b1;
            unique case (st_q)
               SL_LEAD: begin
                  st_q  <= SL_BITS;
                  idx_q <= '0;
                  dat_q <= sh_q[FR_W-1];
                  sh_q  <= {sh_q[FR_W-2:0], 1'b0};
               end
               SL_BITS: begin
                  if (idx_q == IDX_LAST) begin
                     st_q  <= SL_TAIL;
                     trl_q <= '0;
                     dat_q <= 1'b0;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                     dat_q <= sh_q[FR_W-1];
                     sh_q  <= {sh_q[FR_W-2:0], 1'b0};
                  end
               end
               SL_TAIL: begin
                  trl_q <= trl_q + TRL_W'(1);
                  dat_q <= 1'b0;
               end
               default: begin
                  st_q  <= SL_IDLE;
                  dat_q <= 1'b0;
               end
            endcase
         end
      end
   end

   // R12
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall_tk && !clr) |=> $stable(dat_q));

   // R3
   fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_tk && fs_q && !take) |=> !fs_q);

   // R10
   tail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SL_TAIL) |-> (!dat_q && !fs_q));

   // R4
   lead_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SL_LEAD) |-> (fs_q && !dat_q));
endmodule

// File: rtl/iqs_serial_out.sv
`timescale 1ns/1ps
module iqs_serial_out
   import iqs_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              rx_strobe,
   input  logic [1:0]        cfg_clk_mode,
   input  logic              cfg_fs_early,
   input  logic              cfg_clk_inv,
   input  logic              cfg_start_sel,
   input  logic              cfg_trail,
   input  logic [DIV_W-1:0]  cfg_half_div,
   input  logic              smp_valid,
   input  logic [WORD_W-1:0] smp_i,
   input  logic [WORD_W-1:0] smp_q,
   output logic              smp_ready,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              ser_fs
);
   if (WORD_W < 2) begin : g_word_bad
      initial $fatal(1, "iqs_serial_out: WORD_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_div_bad
      initial $fatal(1, "iqs_serial_out: DIV_W must be at least 1");
   end

   logic clr;
   logic run;
   logic busy;
   logic ph;
   logic fall_tk;
   logic act;
   logic vis;

   assign clr = cfg_clk_mode[1];
   assign run = !clr && (port_en || busy);

   iqs_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .half_div (cfg_half_div),
      .ph       (ph),
      .fall_tk  (fall_tk)
   );

   iqs_frame_seq #(.WORD_W(WORD_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .fall_tk   (fall_tk),
      .port_en   (port_en),
      .start_sel (cfg_start_sel),
      .rx_strobe (rx_strobe),
      .fs_early  (cfg_fs_early),
      .trail     (cfg_trail),
      .smp_valid (smp_valid),
      .smp_i     (smp_i),
      .smp_q     (smp_q),
      .smp_ready (smp_ready),
      .dat_q     (ser_data),
      .fs_q      (ser_fs),
      .act_q     (act),
      .busy      (busy)
   );

   always_comb begin
      unique case (cfg_clk_mode)
         CK_GATED: vis = act;
         CK_FREE:  vis = 1'b1;
         default:  vis = 1'b0;
      endcase
   end

   assign ser_clk = cfg_clk_inv ^ (ph && vis);

   // R7
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!ser_data && !ser_fs));

   // R7
   off_noaccept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> !smp_ready);

   // R9
   strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_start_sel && !rx_strobe) |-> !smp_ready);

   // R1
   en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |-> !smp_ready);

   // R3
   accept_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_ready) |=> ser_fs);
endmodule

// File: tb/sim_iqs_serial_out.sv
`timescale 1ns/1ps
module sim_iqs_serial_out;
   localparam int W  = 16;
   localparam int DW = 8;
   localparam int CAP = 1024;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          port_en;
   logic          rx_strobe;
   logic [1:0]    cfg_clk_mode;
   logic          cfg_fs_early;
   logic          cfg_clk_inv;
   logic          cfg_start_sel;
   logic          cfg_trail;
   logic [DW-1:0] cfg_half_div;
   logic          smp_valid;
   logic [W-1:0]  smp_i;
   logic [W-1:0]  smp_q;
   logic          smp_ready;
   logic          ser_clk;
   logic          ser_data;
   logic          ser_fs;

   always #2.5 clk = ~clk;

   iqs_serial_out #(.WORD_W(W), .DIV_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .rx_strobe(rx_strobe),
      .cfg_clk_mode(cfg_clk_mode), .cfg_fs_early(cfg_fs_early),
      .cfg_clk_inv(cfg_clk_inv), .cfg_start_sel(cfg_start_sel),
      .cfg_trail(cfg_trail), .cfg_half_div(cfg_half_div),
      .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
      .smp_ready(smp_ready), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_fs(ser_fs)
   );

   int   n_chk = 0;
   int   n_bad = 0;
   int   cyc = 0;
   int   rise_cnt = 0;
   logic prev_raw = 1'b0;
   logic cap_d [CAP];
   logic cap_f [CAP];
   int   cap_t [CAP];

   // active-edge monitor: records data and sync at every active clock edge
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n === 1'b1 && ((ser_clk ^ cfg_clk_inv) === 1'b1)
          && ((prev_raw ^ cfg_clk_inv) === 1'b0)) begin
         cap_d[rise_cnt % CAP] = ser_data;
         cap_f[rise_cnt % CAP] = ser_fs;
         cap_t[rise_cnt % CAP] = cyc;
         rise_cnt = rise_cnt + 1;
      end
      prev_raw = ser_clk;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic defaults();
      port_en = 0; rx_strobe = 0; cfg_clk_mode = 2'b00; cfg_fs_early = 0;
      cfg_clk_inv = 0; cfg_start_sel = 0; cfg_trail = 0; cfg_half_div = 8'd2;
      smp_valid = 0; smp_i = '0; smp_q = '0;
   endtask

   task automatic settle();
      port_en = 0; smp_valid = 0;
      idle_cycles(400);
   endtask

   // offer a pair and wait for acceptance; returns 1 when accepted
   task automatic offer(input logic [W-1:0] i, input logic [W-1:0] q, input int lim, output bit got);
      got = 0;
      smp_i = i; smp_q = q; smp_valid = 1;
      for (int k = 0; k < lim; k++) begin
         @(negedge clk);
         if (smp_ready) begin got = 1; break; end
      end
      @(negedge clk);
      smp_valid = 0;
   endtask

   task automatic check_frame(input int base, input logic [W-1:0] i, input logic [W-1:0] q,
                              input bit early, input string req);
      logic [2*W-1:0] got;
      int fs_hits;
      int off;
      off = early ? 1 : 0;
      got = '0;
      fs_hits = 0;
      for (int k = 0; k < 2*W; k++) begin
         got[2*W-1-k] = cap_d[(base + off + k) % CAP];
         if (cap_f[(base + off + k) % CAP]) fs_hits += (k == 0) ? 1 : 100;
      end
      chk(got == {i, q}, {req, " R2 bit order"}, got, {i, q});
      if (early) begin
         chk(cap_f[base % CAP] == 1'b1 && cap_d[base % CAP] == 1'b0,
             {req, " R4 lead slot"}, {cap_f[base % CAP], cap_d[base % CAP]}, 2'b10);
         chk(fs_hits == 0, {req, " R4 sync off at MSB"}, fs_hits, 0);
      end else begin
         chk(fs_hits == 1, {req, " R3 sync at MSB only"}, fs_hits, 1);
      end
   endtask

   task automatic t_reset();
      chk(ser_clk == 0 && ser_data == 0 && ser_fs == 0 && smp_ready == 0,
          "R1 reset outputs", {ser_clk, ser_data, ser_fs, smp_ready}, 0);
      begin
         bit got;
         offer(16'h1111, 16'h2222, 100, got);
         chk(!got, "R1 no accept while disabled", got, 0);
      end
   endtask

   task automatic t_basic();
      int base; bit got;
      base = rise_cnt;
      port_en = 1;
      idle_cycles(40);
      offer(16'hA5C3, 16'h1E7F, 200, got);
      chk(got, "R2 accepted", got, 1);
      idle_cycles(300);
      chk(rise_cnt - base == 2*W, "R5 R10 edge count gated", rise_cnt - base, 2*W);
      check_frame(base, 16'hA5C3, 16'h1E7F, 0, "basic");
      settle();
   endtask

   task automatic t_early();
      int base; bit got;
      cfg_fs_early = 1;
      base = rise_cnt;
      port_en = 1;
      offer(16'h8001, 16'hFFFE, 200, got);
      idle_cycles(300);
      chk(rise_cnt - base == 2*W + 1, "R4 edge count", rise_cnt - base, 2*W + 1);
      check_frame(base, 16'h8001, 16'hFFFE, 1, "early");
      settle();
      cfg_fs_early = 0;
   endtask

   task automatic t_free();
      int base; int bad_gap; int bad_lvl;
      cfg_clk_mode = 2'b01;
      cfg_half_div = 8'd3;
      base = rise_cnt;
      port_en = 1;
      idle_cycles(120);
      chk(rise_cnt - base >= 15, "R6 free clock runs", rise_cnt - base, 15);
      bad_gap = 0; bad_lvl = 0;
      for (int k = base + 1; k < rise_cnt; k++)
         if (cap_t[k % CAP] - cap_t[(k - 1) % CAP] != 6) bad_gap++;
      for (int k = base; k < rise_cnt; k++)
         if (cap_d[k % CAP] || cap_f[k % CAP]) bad_lvl++;
      chk(bad_gap == 0, "R13 period 2*half_div", bad_gap, 0);
      chk(bad_lvl == 0, "R6 idle data and sync low", bad_lvl, 0);
      settle();
      cfg_clk_mode = 2'b00;
      cfg_half_div = 8'd2;
   endtask

   task automatic t_off();
      int base; int seen_rdy; int seen_out; bit got;
      cfg_clk_mode = 2'b10;
      base = rise_cnt;
      port_en = 1;
      seen_rdy = 0; seen_out = 0;
      smp_i = 16'hFFFF; smp_q = 16'hFFFF; smp_valid = 1;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (smp_ready) seen_rdy++;
         if (ser_data || ser_fs || ser_clk) seen_out++;
      end
      smp_valid = 0;
      chk(seen_rdy == 0, "R7 no accept when off", seen_rdy, 0);
      chk(seen_out == 0 && rise_cnt == base, "R7 outputs quiet", seen_out + rise_cnt - base, 0);
      cfg_clk_mode = 2'b11;
      offer(16'h0F0F, 16'hF0F0, 100, got);
      chk(!got && rise_cnt == base, "R7 mode 11 quiet", rise_cnt - base, 0);
      settle();
      cfg_clk_mode = 2'b00;
   endtask

   task automatic t_inv();
      int base; bit got;
      cfg_clk_inv = 1;
      idle_cycles(4);
      chk(ser_clk == 1'b1, "R8 idle level high", ser_clk, 1);
      base = rise_cnt;
      port_en = 1;
      offer(16'h3C96, 16'h6B2D, 200, got);
      idle_cycles(300);
      chk(rise_cnt - base == 2*W, "R8 edge count", rise_cnt - base, 2*W);
      check_frame(base, 16'h3C96, 16'h6B2D, 0, "R8 inverted");
      settle();
      cfg_clk_inv = 0;
      idle_cycles(4);
   endtask

   task automatic t_strobe();
      int base; int seen; bit got;
      cfg_start_sel = 1;
      rx_strobe = 0;
      base = rise_cnt;
      port_en = 1;
      seen = 0;
      smp_i = 16'h1357; smp_q = 16'h9BDF; smp_valid = 1;
      for (int k = 0; k < 150; k++) begin
         @(negedge clk);
         if (smp_ready) seen++;
      end
      chk(seen == 0 && rise_cnt == base, "R9 held without strobe", seen + rise_cnt - base, 0);
      rx_strobe = 1;
      offer(16'h1357, 16'h9BDF, 200, got);
      chk(got, "R9 starts on strobe", got, 1);
      idle_cycles(300);
      check_frame(base, 16'h1357, 16'h9BDF, 0, "R9 strobe");
      settle();
      rx_strobe = 0;
      cfg_start_sel = 0;
   endtask

   task automatic t_drop_trail();
      int base; int tail_bad; bit got;
      cfg_trail = 1;
      base = rise_cnt;
      port_en = 1;
      offer(16'hC0DE, 16'h4321, 200, got);
      port_en = 0;
      idle_cycles(400);
      chk(rise_cnt - base == 2*W + 5, "R10 R11 edges with tail", rise_cnt - base, 2*W + 5);
      check_frame(base, 16'hC0DE, 16'h4321, 0, "R11 after disable");
      tail_bad = 0;
      for (int k = 0; k < 5; k++)
         if (cap_d[(base + 2*W + k) % CAP] || cap_f[(base + 2*W + k) % CAP]) tail_bad++;
      chk(tail_bad == 0, "R10 tail slots quiet", tail_bad, 0);
      settle();
      cfg_trail = 0;
   endtask

   task automatic t_b2b();
      int base; bit g1; bit g2;
      base = rise_cnt;
      port_en = 1;
      smp_i = 16'hDEAD; smp_q = 16'hBEEF; smp_valid = 1;
      g1 = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (smp_ready) begin g1 = 1; break; end
      end
      @(negedge clk);
      smp_i = 16'h0123; smp_q = 16'h4567;
      offer(16'h0123, 16'h4567, 400, g2);
      idle_cycles(300);
      chk(g1 && g2, "R14 both accepted", {g1, g2}, 2'b11);
      chk(rise_cnt - base == 4*W, "R14 no gap edges", rise_cnt - base, 4*W);
      check_frame(base, 16'hDEAD, 16'hBEEF, 0, "R14 first");
      check_frame(base + 2*W, 16'h0123, 16'h4567, 0, "R14 second");
      settle();
   endtask

   initial begin
      #(150000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      defaults();
      rst_n = 0;
      idle_cycles(5);
      rst_n = 1;
      idle_cycles(3);
      t_reset();
      t_basic();
      t_early();
      t_free();
      t_off();
      t_inv();
      t_strobe();
      t_drop_trail();
      t_b2b();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule